// File: doc/BRIEF.md
# SPI Packet Loop Sequencer

This block is the control sequencer of an SPI master. It turns a transfer request into a run of bytes arranged as a number of packets of equal size. It tells the serial engine when the transfer runs, marks the start of each transfer and the end of each packet, and says when chip-select must stay asserted. The serial engine reports each completed byte with a one-cycle strobe. Data movement is handled elsewhere.

Two fields set the length of a transfer. One gives the bytes per packet minus one. The other gives the packets per transfer minus one. Both are captured when a transfer starts.

With pause mode enabled, the transfer does not return to idle when it ends. Chip-select stays asserted and the sequencer waits in a paused state. A separate resume command then starts the next transfer without releasing chip-select. An interrupt flag can be raised at the end of a transfer. It is cleared by a status read or by a soft reset.

Top module: `spi_pkt_sequencer`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `cs_hold`, `paused`, `frame_start`, `pkt_end` and `irq` are all 0.
- R2: A `cmd_go` pulse while idle sets `busy` and `cs_hold` on the next cycle. `frame_start` is high for exactly that one cycle.
- R3: Each packet is `pkt_len`+1 byte strobes long (`pkt_len` is 10 bits, up to 1024 bytes). `pkt_end` pulses for one cycle after the last byte of each packet.
- R4: A transfer is (`pkt_len`+1)×(`pkt_loop`+1) byte strobes long (`pkt_loop` is 8 bits). `busy` stays high until the last of these strobes and drops in the cycle after it.
- R5: If `pause_en` is 1 when the last byte completes, the sequencer enters the paused state. In that state `paused` is 1, `cs_hold` stays 1 and `busy` is 0. If `pause_en` is 0, the sequencer returns to idle with `cs_hold` at 0.
- R6: A `cmd_resume` pulse while paused starts a new transfer: `busy` goes to 1 and `frame_start` pulses, with the length fields sampled again.
- R7: `cmd_go` while paused is ignored, and `cmd_resume` while idle is ignored.
- R8: `cmd_softrst` returns the sequencer to idle from any state, deasserts `cs_hold` and clears `irq`.
- R9: When a transfer ends, `irq` is set if `fin_ie` is 1 (ending in idle) or if `pause_ie` is 1 (ending in the paused state). Otherwise `irq` stays 0.
- R10: A `stat_rd` pulse clears `irq`. The `paused` indication is not changed by the read.
- R11: If `pause_en` is cleared while paused, the next resumed transfer ends in idle with `cs_hold` deasserted.
- R12: `byte_done` strobes while idle or paused are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Activate: starts a transfer from idle |
| cmd_resume | input | 1 | Resume: starts the next transfer from paused |
| cmd_softrst | input | 1 | Soft reset to idle |
| pause_en | input | 1 | End each transfer in the paused state with CS held |
| fin_ie | input | 1 | Interrupt enable for a transfer ending in idle |
| pause_ie | input | 1 | Interrupt enable for a transfer ending in paused |
| pkt_len | input | 10 | Bytes per packet minus one |
| pkt_loop | input | 8 | Packets per transfer minus one |
| byte_done | input | 1 | One-cycle strobe per byte completed by the engine |
| stat_rd | input | 1 | Status read strobe; clears the interrupt flag |
| busy | output | 1 | Transfer running; the engine shifts bytes |
| frame_start | output | 1 | One-cycle pulse at the start of a transfer |
| pkt_end | output | 1 | One-cycle pulse after the last byte of a packet |
| cs_hold | output | 1 | Chip-select must be asserted |
| paused | output | 1 | Status: 1 while paused, 0 otherwise |
| irq | output | 1 | Interrupt flag |

## Verification
The bound checker checks these rules on every cycle:
- a start pulse only ever comes with a running transfer;
- a packet-end pulse always follows a byte strobe;
- a soft reset always leaves chip-select released and the flag clear;
- a status read outside a transfer always clears the flag;
- an activate command while paused, or a stray byte strobe outside a transfer, leaves the state unchanged.

The directed scenarios cover what needs counting over whole transfers:
- exact packet and transfer lengths, including the 1024-byte packet and the 256-packet loop;
- the gating of the two interrupt enables;
- pause and resume chains;
- the effect of clearing pause enable while paused.

// File: rtl/spi_pkt_sequencer.sv
module spi_pkt_sequencer #(
  parameter int LEN_W  = 10,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_resume,
  input  logic              cmd_softrst,
  input  logic              pause_en,
  input  logic              fin_ie,
  input  logic              pause_ie,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [LOOP_W-1:0] pkt_loop,
  input  logic              byte_done,
  input  logic              stat_rd,
  output logic              busy,
  output logic              frame_start,
  output logic              pkt_end,
  output logic              cs_hold,
  output logic              paused,
  output logic              irq
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PAUSE} seq_state_t;

  seq_state_t        st;
  logic [LEN_W-1:0]  len_q, byte_cnt;
  logic [LOOP_W-1:0] loop_q, pkt_cnt;

  wire last_byte = (byte_cnt == len_q);
  wire last_pkt  = (pkt_cnt == loop_q);
  wire start     = (st == S_IDLE && cmd_go) || (st == S_PAUSE && cmd_resume);
  wire step      = (st == S_RUN) && byte_done;
  wire finish    = step && last_byte && last_pkt;
  wire irq_set   = finish && (pause_en ? pause_ie : fin_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      len_q       <= '0;
      loop_q      <= '0;
      byte_cnt    <= '0;
      pkt_cnt     <= '0;
      frame_start <= 1'b0;
      pkt_end     <= 1'b0;
      irq         <= 1'b0;
    end else if (cmd_softrst) begin
      st          <= S_IDLE;
      byte_cnt    <= '0;
      pkt_cnt     <= '0;
      frame_start <= 1'b0;
      pkt_end     <= 1'b0;
      irq         <= 1'b0;
    end else begin
      frame_start <= start;
      pkt_end     <= step && last_byte;
      if (irq_set)      irq <= 1'b1;
      else if (stat_rd) irq <= 1'b0;
      if (start) begin
        st       <= S_RUN;
        len_q    <= pkt_len;
        loop_q   <= pkt_loop;
        byte_cnt <= '0;
        pkt_cnt  <= '0;
      end else if (step) begin
        if (last_byte) begin
          byte_cnt <= '0;
          pkt_cnt  <= pkt_cnt + 1'b1;
          if (last_pkt) st <= pause_en ? S_PAUSE : S_IDLE;
        end else begin
          byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
  end

  assign busy    = (st == S_RUN);
  assign cs_hold = (st != S_IDLE);
  assign paused  = (st == S_PAUSE);
endmodule

module spi_pkt_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_go,
  input logic cmd_resume,
  input logic cmd_softrst,
  input logic byte_done,
  input logic stat_rd,
  input logic busy,
  input logic frame_start,
  input logic pkt_end,
  input logic cs_hold,
  input logic paused,
  input logic irq
);
  // R2
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> busy);
  // R3
  pkt_end_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> $past(byte_done));
  // R8
  softrst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_softrst |=> (!cs_hold && !irq));
  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !busy && !cmd_softrst) |=> !irq);
  // R7
  go_in_pause_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && cmd_go && !cmd_resume && !cmd_softrst) |=> (paused && !frame_start));
  // R12
  stray_byte_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && byte_done && !cmd_go && !cmd_resume && !cmd_softrst) |=>
      ($stable(paused) && $stable(cs_hold) && !busy));
endmodule

bind spi_pkt_sequencer spi_pkt_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_resume(cmd_resume),
  .cmd_softrst(cmd_softrst), .byte_done(byte_done), .stat_rd(stat_rd),
  .busy(busy), .frame_start(frame_start), .pkt_end(pkt_end),
  .cs_hold(cs_hold), .paused(paused), .irq(irq)
);

// File: tb/spi_pkt_sequencer_test.sv
module spi_pkt_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_go = 0, cmd_resume = 0, cmd_softrst = 0;
  logic pause_en = 0, fin_ie = 0, pause_ie = 0;
  logic [9:0] pkt_len = '0;
  logic [7:0] pkt_loop = '0;
  logic byte_done = 0, stat_rd = 0;
  logic busy, frame_start, pkt_end, cs_hold, paused, irq;

  int tests = 0, fails = 0, pe_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_pkt_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_resume(cmd_resume),
    .cmd_softrst(cmd_softrst), .pause_en(pause_en), .fin_ie(fin_ie),
    .pause_ie(pause_ie), .pkt_len(pkt_len), .pkt_loop(pkt_loop),
    .byte_done(byte_done), .stat_rd(stat_rd), .busy(busy),
    .frame_start(frame_start), .pkt_end(pkt_end), .cs_hold(cs_hold),
    .paused(paused), .irq(irq)
  );

  always @(negedge clk) if (pkt_end) pe_cnt++;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_go();     cmd_go = 1;      @(negedge clk); cmd_go = 0;      endtask
  task automatic pulse_resume(); cmd_resume = 1;  @(negedge clk); cmd_resume = 0;  endtask
  task automatic pulse_srst();   cmd_softrst = 1; @(negedge clk); cmd_softrst = 0; endtask
  task automatic pulse_rd();     stat_rd = 1;     @(negedge clk); stat_rd = 0;     endtask
  task automatic send_bytes(int n);
    byte_done = 1;
    repeat (n) @(negedge clk);
    byte_done = 0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 cs_hold", cs_hold, 0);
    check("R1 paused", paused, 0);
    check("R1 irq", irq, 0);
    check("R1 frame_start", frame_start, 0);
    check("R1 pkt_end", pkt_end, 0);
  endtask

  task automatic t_basic();
    pause_en = 0; fin_ie = 1; pkt_len = 2; pkt_loop = 1;
    pe_cnt = 0;
    pulse_go();
    check("R2 busy", busy, 1);
    check("R2 cs_hold", cs_hold, 1);
    check("R2 frame_start", frame_start, 1);
    @(negedge clk);
    check("R2 frame_start one cycle", frame_start, 0);
    send_bytes(5);
    check("R4 busy before last byte", busy, 1);
    @(negedge clk);
    check("R3 one packet end", pe_cnt, 1);
    send_bytes(1);
    check("R4 idle after last byte", busy, 0);
    check("R5 cs released", cs_hold, 0);
    check("R9 finish irq", irq, 1);
    @(negedge clk);
    check("R3 two packet ends", pe_cnt, 2);
    pulse_rd();
    check("R10 read clears irq", irq, 0);
  endtask

  task automatic t_gate();
    fin_ie = 0; pause_en = 0; pkt_len = 0; pkt_loop = 0;
    pulse_go();
    send_bytes(1);
    check("R4 single byte transfer", busy, 0);
    check("R9 fin_ie gates irq", irq, 0);
  endtask

  task automatic t_pause();
    pause_en = 1; pause_ie = 1; fin_ie = 0; pkt_len = 1; pkt_loop = 0;
    pulse_go();
    send_bytes(2);
    check("R5 paused", paused, 1);
    check("R5 cs held", cs_hold, 1);
    check("R5 not busy", busy, 0);
    check("R9 pause irq", irq, 1);
    pulse_rd();
    check("R10 irq cleared", irq, 0);
    check("R10 paused kept", paused, 1);
    pulse_go();
    check("R7 go ignored while paused", paused, 1);
    check("R7 no start", frame_start, 0);
    send_bytes(3);
    check("R12 bytes ignored while paused", paused, 1);
    check("R12 still not busy", busy, 0);
    pkt_len = 0; pkt_loop = 2;
    pulse_resume();
    check("R6 resume runs", busy, 1);
    check("R6 resume start pulse", frame_start, 1);
    send_bytes(2);
    check("R6 new length sampled", busy, 1);
    send_bytes(1);
    check("R5 paused again", paused, 1);
    pause_en = 0;
    pulse_resume();
    send_bytes(3);
    check("R11 ends in idle", paused, 0);
    check("R11 cs released", cs_hold, 0);
    pulse_rd();
    pause_ie = 0;
  endtask

  task automatic t_idle_ignore();
    pulse_resume();
    check("R7 resume ignored while idle", busy, 0);
    check("R7 cs stays released", cs_hold, 0);
    send_bytes(4);
    check("R12 bytes ignored while idle", cs_hold, 0);
    check("R12 not paused", paused, 0);
  endtask

  task automatic t_srst();
    pause_en = 0; pkt_len = 5; pkt_loop = 0;
    pulse_go();
    send_bytes(2);
    pulse_srst();
    check("R8 idle from run", busy, 0);
    check("R8 cs released from run", cs_hold, 0);
    pause_en = 1; pause_ie = 1; pkt_len = 0;
    pulse_go();
    send_bytes(1);
    check("R8 setup paused", paused, 1);
    pulse_srst();
    check("R8 paused cleared", paused, 0);
    check("R8 irq cleared", irq, 0);
    check("R8 cs released", cs_hold, 0);
    pause_en = 0; pause_ie = 0;
  endtask

  task automatic t_max();
    fin_ie = 1; pkt_len = 10'd1023; pkt_loop = 0;
    pe_cnt = 0;
    pulse_go();
    send_bytes(1023);
    check("R3 1024-byte packet not done", busy, 1);
    send_bytes(1);
    check("R3 1024-byte packet done", busy, 0);
    pulse_rd();
    pkt_len = 0; pkt_loop = 8'd255;
    pulse_go();
    send_bytes(255);
    check("R4 256 packets not done", busy, 1);
    send_bytes(1);
    check("R4 256 packets done", busy, 0);
    @(negedge clk);
    check("R3 packet end count", pe_cnt, 257);
    pulse_rd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gate();
    t_pause();
    t_idle_ignore();
    t_srst();
    t_max();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule